// File: doc/BRIEF.md
# Scoreboarded Warp Issue Scheduler

This block sits between instruction fetch and two execute pipes of a multithreaded SIMD core. It keeps one waiting instruction per warp. Each entry names an execute class, one destination register and two source registers. A per-warp register scoreboard records which destinations still have results in flight. Every cycle the block grants at most one ready warp, removes that warp's instruction from the buffer and presents it on a registered issue port. The issue port stands for one broadcast issue to all threads of the warp.

Each execute class, the multiply-add class and the special-function class, is 8 lanes wide. A warp instruction therefore holds its class for four cycles, one quarter-warp per cycle. A small state machine per class tracks this occupancy. While one class is occupied, the other class can still be fed, so the two interleave. The fetch side writes one warp's slot per cycle, using the slot-occupancy vector to find free slots. The retire side clears scoreboard entries through a writeback port.

Top module: `wis_issue_sched`

Each class tracker has two named states and four named transitions:
- States: PIPE_IDLE (the class accepts an instruction) and PIPE_BUSY (the class is counting down its occupancy).
- `start` moves PIPE_IDLE to PIPE_BUSY.
- `count` keeps PIPE_BUSY while the remaining count is non-zero.
- `expire` moves PIPE_BUSY back to PIPE_IDLE.
- `hold` keeps PIPE_IDLE when nothing starts.

## Requirements
- R1: After reset no instruction issues (issue_valid low) and every slot_busy bit is 0.
- R2: A fill to warp w sets slot_busy[w] after that clock edge and stores the instruction. A fill aimed at a slot that is occupied in that cycle is ignored, and the stored instruction is unchanged.
- R3: At most one instruction issues per cycle. The issue port carries the buffered class, destination, sources and opcode of the granted warp, one cycle after the grant edge. The slot becomes free at the grant edge and can be filled again in the next cycle.
- R4: A buffered instruction is not eligible while its destination register or either source register is marked pending for its own warp.
- R5: On issue the destination register is marked pending for that warp. A writeback clears the mark, taking effect from the next cycle. If a writeback and a mark hit the same warp and register in the same cycle, the register stays pending.
- R6: Among eligible warps, the first one at or after the round-robin pointer, in ascending warp order with wrap, wins. The pointer then moves to the warp after the winner. With no eligible warp nothing issues and the pointer holds.
- R7: The issue_class encoding is 0 for multiply-add and 1 for special-function. Two instructions of the same class issue at least 4 cycles apart.
- R8: While one class is occupied, an eligible instruction of the other class still issues.
- R9: A warp whose earlier destinations are still pending keeps issuing instructions that touch none of those registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | Write one instruction into a warp slot |
| fill_warp | input | WARP_W | Target warp of the fill |
| fill_class | input | 1 | Execute class: 0 multiply-add, 1 special-function |
| fill_dst | input | REG_W | Destination register |
| fill_src0 | input | REG_W | First source register |
| fill_src1 | input | REG_W | Second source register |
| fill_op | input | OP_W | Opaque opcode payload |
| wb_valid | input | 1 | Clear one scoreboard entry |
| wb_warp | input | WARP_W | Warp of the writeback |
| wb_reg | input | REG_W | Register of the writeback |
| slot_busy | output | NUM_WARPS | Per-warp slot occupancy |
| issue_valid | output | 1 | An instruction issued |
| issue_warp | output | WARP_W | Issued warp |
| issue_class | output | 1 | Issued execute class |
| issue_dst | output | REG_W | Issued destination register |
| issue_src0 | output | REG_W | Issued first source |
| issue_src1 | output | REG_W | Issued second source |
| issue_op | output | OP_W | Issued opcode payload |

## Verification
The bench targets four corner cases:
- A read of a register still in flight. A scheduler that skipped the check would issue the dependent instruction early, before the writeback.
- A writeback arriving in the same cycle as a new mark to the same register. A design that gave the writeback priority would release a later reader too soon.
- Same-class issues spaced exactly four cycles apart, with a different-class instruction squeezed in between. An off-by-one counter shows up as a grant one cycle early or late. A tracker that blocked both classes would delay the squeezed instruction.
- Round-robin order after a wrap, and a fill aimed at an occupied slot. A wrong pointer picks the lower warp first. An overwrite would change the destination that finally issues.

// File: rtl/wis_pkg.sv
package wis_pkg;

    typedef enum logic {
        CLS_MAD = 1'b0,
        CLS_SFU = 1'b1
    } exec_class_e;

    typedef enum logic {
        PIPE_IDLE = 1'b0,
        PIPE_BUSY = 1'b1
    } pipe_state_e;

    localparam int NUM_CLASSES = 2;

endpackage

// File: rtl/wis_slot_buf.sv
module wis_slot_buf #(
    parameter int NUM_WARPS = 24,
    parameter int WARP_W    = 5,
    parameter int REG_W     = 4,
    parameter int OP_W      = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              fill_valid,
    input  logic [WARP_W-1:0]                 fill_warp,
    input  logic                              fill_class,
    input  logic [REG_W-1:0]                  fill_dst,
    input  logic [REG_W-1:0]                  fill_src0,
    input  logic [REG_W-1:0]                  fill_src1,
    input  logic [OP_W-1:0]                   fill_op,
    input  logic                              free_en,
    input  logic [WARP_W-1:0]                 free_warp,
    output logic [NUM_WARPS-1:0]              vld,
    output logic [NUM_WARPS-1:0]              cls,
    output logic [NUM_WARPS-1:0][REG_W-1:0]   dst,
    output logic [NUM_WARPS-1:0][REG_W-1:0]   src0,
    output logic [NUM_WARPS-1:0][REG_W-1:0]   src1,
    output logic [NUM_WARPS-1:0][OP_W-1:0]    op
);

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
        logic take;
        assign take = fill_valid && (fill_warp == WARP_W'(w)) && !vld[w];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld[w]  <= 1'b0;
                cls[w]  <= 1'b0;
                dst[w]  <= '0;
                src0[w] <= '0;
                src1[w] <= '0;
                op[w]   <= '0;
            end else begin
                if (free_en && (free_warp == WARP_W'(w))) begin
                    vld[w] <= 1'b0;
                end else if (take) begin
                    vld[w] <= 1'b1;
                end
                if (take) begin
                    cls[w]  <= fill_class;
                    dst[w]  <= fill_dst;
                    src0[w] <= fill_src0;
                    src1[w] <= fill_src1;
                    op[w]   <= fill_op;
                end
            end
        end
    end

endmodule

// File: rtl/wis_scoreboard.sv
module wis_scoreboard #(
    parameter int NUM_WARPS = 24,
    parameter int NUM_REGS  = 16,
    parameter int WARP_W    = 5,
    parameter int REG_W     = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 mark_en,
    input  logic [WARP_W-1:0]                    mark_warp,
    input  logic [REG_W-1:0]                     mark_reg,
    input  logic                                 clr_en,
    input  logic [WARP_W-1:0]                    clr_warp,
    input  logic [REG_W-1:0]                     clr_reg,
    output logic [NUM_WARPS-1:0][NUM_REGS-1:0]   pend
);

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        logic [NUM_REGS-1:0] set_mask;
        logic [NUM_REGS-1:0] clr_mask;

        always_comb begin
            set_mask = '0;
            clr_mask = '0;
            if (mark_en && (mark_warp == WARP_W'(w))) begin
                set_mask[mark_reg] = 1'b1;
            end
            if (clr_en && (clr_warp == WARP_W'(w))) begin
                clr_mask[clr_reg] = 1'b1;
            end
        end

        // A new mark overrides a same-cycle clear.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend[w] <= '0;
            end else begin
                pend[w] <= (pend[w] & ~clr_mask) | set_mask;
            end
        end
    end

endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
    parameter int NUM_WARPS = 24,
    parameter int WARP_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WARPS-1:0] elig,
    output logic                 gnt_valid,
    output logic [WARP_W-1:0]    gnt_idx,
    output logic [NUM_WARPS-1:0] gnt_onehot
);

    logic [WARP_W-1:0] ptr;

    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int i = 0; i < NUM_WARPS; i++) begin
            int k;
            k = int'(ptr) + i;
            if (k >= NUM_WARPS) begin
                k = k - NUM_WARPS;
            end
            if (!gnt_valid && elig[k]) begin
                gnt_valid = 1'b1;
                gnt_idx   = WARP_W'(k);
            end
        end
    end

    always_comb begin
        gnt_onehot = '0;
        if (gnt_valid) begin
            gnt_onehot[gnt_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (gnt_valid) begin
            if (gnt_idx == WARP_W'(NUM_WARPS - 1)) begin
                ptr <= '0;
            end else begin
                ptr <= gnt_idx + WARP_W'(1);
            end
        end
    end

endmodule

// File: rtl/wis_pipe_occ.sv
module wis_pipe_occ
    import wis_pkg::*;
#(
    parameter int OCC_CYCLES = 4,
    localparam int CNT_W     = $clog2(OCC_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic free
);

    pipe_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIPE_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PIPE_IDLE: begin
                if (start && (OCC_CYCLES > 1)) begin
                    state_d = PIPE_BUSY;
                    cnt_d   = CNT_W'(OCC_CYCLES - 2);
                end
            end
            PIPE_BUSY: begin
                if (cnt_q == '0) begin
                    state_d = PIPE_IDLE;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: state_d = PIPE_IDLE;
        endcase
    end

    always_comb begin
        free = (state_q == PIPE_IDLE);
    end

endmodule

// File: rtl/wis_issue_sched.sv
module wis_issue_sched
    import wis_pkg::*;
#(
    parameter int NUM_WARPS  = 24,
    parameter int NUM_REGS   = 16,
    parameter int OP_W       = 8,
    parameter int OCC_CYCLES = 4,
    localparam int WARP_W    = $clog2(NUM_WARPS),
    localparam int REG_W     = $clog2(NUM_REGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fill_valid,
    input  logic [WARP_W-1:0]    fill_warp,
    input  logic                 fill_class,
    input  logic [REG_W-1:0]     fill_dst,
    input  logic [REG_W-1:0]     fill_src0,
    input  logic [REG_W-1:0]     fill_src1,
    input  logic [OP_W-1:0]      fill_op,
    input  logic                 wb_valid,
    input  logic [WARP_W-1:0]    wb_warp,
    input  logic [REG_W-1:0]     wb_reg,
    output logic [NUM_WARPS-1:0] slot_busy,
    output logic                 issue_valid,
    output logic [WARP_W-1:0]    issue_warp,
    output logic                 issue_class,
    output logic [REG_W-1:0]     issue_dst,
    output logic [REG_W-1:0]     issue_src0,
    output logic [REG_W-1:0]     issue_src1,
    output logic [OP_W-1:0]      issue_op
);

    logic [NUM_WARPS-1:0]              s_vld;
    logic [NUM_WARPS-1:0]              s_cls;
    logic [NUM_WARPS-1:0][REG_W-1:0]   s_dst;
    logic [NUM_WARPS-1:0][REG_W-1:0]   s_src0;
    logic [NUM_WARPS-1:0][REG_W-1:0]   s_src1;
    logic [NUM_WARPS-1:0][OP_W-1:0]    s_op;
    logic [NUM_WARPS-1:0][NUM_REGS-1:0] sb_pend;
    logic [NUM_WARPS-1:0]              elig;
    logic                              gnt_valid;
    logic [WARP_W-1:0]                 gnt_idx;
    logic [NUM_WARPS-1:0]              gnt_onehot;
    logic [NUM_CLASSES-1:0]            cls_free;

    wis_slot_buf #(
        .NUM_WARPS(NUM_WARPS), .WARP_W(WARP_W), .REG_W(REG_W), .OP_W(OP_W)
    ) u_slots (
        .clk(clk), .rst_n(rst_n),
        .fill_valid(fill_valid), .fill_warp(fill_warp), .fill_class(fill_class),
        .fill_dst(fill_dst), .fill_src0(fill_src0), .fill_src1(fill_src1),
        .fill_op(fill_op),
        .free_en(gnt_valid), .free_warp(gnt_idx),
        .vld(s_vld), .cls(s_cls), .dst(s_dst), .src0(s_src0), .src1(s_src1),
        .op(s_op)
    );

    wis_scoreboard #(
        .NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .WARP_W(WARP_W), .REG_W(REG_W)
    ) u_sb (
        .clk(clk), .rst_n(rst_n),
        .mark_en(gnt_valid), .mark_warp(gnt_idx), .mark_reg(s_dst[gnt_idx]),
        .clr_en(wb_valid), .clr_warp(wb_warp), .clr_reg(wb_reg),
        .pend(sb_pend)
    );

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        logic start_c;
        assign start_c = gnt_valid && (s_cls[gnt_idx] == c[0]);
        wis_pipe_occ #(.OCC_CYCLES(OCC_CYCLES)) u_occ (
            .clk(clk), .rst_n(rst_n), .start(start_c), .free(cls_free[c])
        );
    end

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_elig
        assign elig[w] = s_vld[w]
                       && !sb_pend[w][s_src0[w]]
                       && !sb_pend[w][s_src1[w]]
                       && !sb_pend[w][s_dst[w]]
                       && cls_free[s_cls[w]];
    end

    wis_rr_pick #(.NUM_WARPS(NUM_WARPS), .WARP_W(WARP_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .elig(elig),
        .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .gnt_onehot(gnt_onehot)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issue_valid <= 1'b0;
            issue_warp  <= '0;
            issue_class <= 1'b0;
            issue_dst   <= '0;
            issue_src0  <= '0;
            issue_src1  <= '0;
            issue_op    <= '0;
        end else begin
            issue_valid <= gnt_valid;
            if (gnt_valid) begin
                issue_warp  <= gnt_idx;
                issue_class <= s_cls[gnt_idx];
                issue_dst   <= s_dst[gnt_idx];
                issue_src0  <= s_src0[gnt_idx];
                issue_src1  <= s_src1[gnt_idx];
                issue_op    <= s_op[gnt_idx];
            end
        end
    end

    assign slot_busy = s_vld;

endmodule

// File: rtl/wis_issue_checker.sv
module wis_issue_checker #(
    parameter int NUM_WARPS  = 24,
    parameter int NUM_REGS   = 16,
    parameter int OCC_CYCLES = 4,
    parameter int WARP_W     = 5,
    parameter int REG_W      = 4
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               fill_valid,
    input logic [WARP_W-1:0]                  fill_warp,
    input logic [NUM_WARPS-1:0]               slot_busy,
    input logic                               issue_valid,
    input logic [WARP_W-1:0]                  issue_warp,
    input logic                               issue_class,
    input logic [REG_W-1:0]                   issue_dst,
    input logic                               gnt_valid,
    input logic [WARP_W-1:0]                  gnt_idx,
    input logic [NUM_WARPS-1:0]               gnt_onehot,
    input logic [NUM_WARPS-1:0][NUM_REGS-1:0] pend,
    input logic [NUM_WARPS-1:0][REG_W-1:0]    s_dst,
    input logic [NUM_WARPS-1:0][REG_W-1:0]    s_src0,
    input logic [NUM_WARPS-1:0][REG_W-1:0]    s_src1
);

    localparam int GAP_W = $clog2(OCC_CYCLES + 1);
    logic [1:0][GAP_W-1:0] since;

    for (genvar c = 0; c < 2; c++) begin : g_gap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                since[c] <= GAP_W'(OCC_CYCLES);
            end else if (issue_valid && (issue_class == c[0])) begin
                since[c] <= GAP_W'(1);
            end else if (since[c] < GAP_W'(OCC_CYCLES)) begin
                since[c] <= since[c] + GAP_W'(1);
            end
        end
    end

    a_r2_fill_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && (int'(fill_warp) < NUM_WARPS) && !slot_busy[fill_warp])
        |=> slot_busy[$past(fill_warp)]);

    a_r3_slot_freed: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !slot_busy[issue_warp]);

    a_r4_pick_ready: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (!pend[gnt_idx][s_src0[gnt_idx]]
                    && !pend[gnt_idx][s_src1[gnt_idx]]
                    && !pend[gnt_idx][s_dst[gnt_idx]]));

    a_r5_dst_marked: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> pend[issue_warp][issue_dst]);

    a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_onehot) && (gnt_valid == (gnt_onehot != '0)));

    a_r7_mad_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !issue_class) |-> (since[0] >= GAP_W'(OCC_CYCLES)));

    a_r7_sfu_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_class) |-> (since[1] >= GAP_W'(OCC_CYCLES)));

endmodule

bind wis_issue_sched wis_issue_checker #(
    .NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .OCC_CYCLES(OCC_CYCLES),
    .WARP_W(WARP_W), .REG_W(REG_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_warp(fill_warp),
    .slot_busy(slot_busy), .issue_valid(issue_valid), .issue_warp(issue_warp),
    .issue_class(issue_class), .issue_dst(issue_dst),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .gnt_onehot(gnt_onehot),
    .pend(sb_pend), .s_dst(s_dst), .s_src0(s_src0), .s_src1(s_src1)
);

// File: tb/tb_wis_issue_sched.sv
`timescale 1ns/1ps
module tb_wis_issue_sched;

    localparam int NW  = 24;
    localparam int NR  = 16;
    localparam int OPW = 8;
    localparam int OCC = 4;
    localparam int WW  = $clog2(NW);
    localparam int RW  = $clog2(NR);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fill_valid = 1'b0;
    logic [WW-1:0] fill_warp = '0;
    logic fill_class = 1'b0;
    logic [RW-1:0] fill_dst = '0, fill_src0 = '0, fill_src1 = '0;
    logic [OPW-1:0] fill_op = '0;
    logic wb_valid = 1'b0;
    logic [WW-1:0] wb_warp = '0;
    logic [RW-1:0] wb_reg = '0;
    logic [NW-1:0] slot_busy;
    logic issue_valid, issue_class;
    logic [WW-1:0] issue_warp;
    logic [RW-1:0] issue_dst, issue_src0, issue_src1;
    logic [OPW-1:0] issue_op;

    always #4 clk = ~clk;

    wis_issue_sched #(.NUM_WARPS(NW), .NUM_REGS(NR), .OP_W(OPW), .OCC_CYCLES(OCC)) dut (
        .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_warp(fill_warp),
        .fill_class(fill_class), .fill_dst(fill_dst), .fill_src0(fill_src0),
        .fill_src1(fill_src1), .fill_op(fill_op), .wb_valid(wb_valid),
        .wb_warp(wb_warp), .wb_reg(wb_reg), .slot_busy(slot_busy),
        .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_class(issue_class),
        .issue_dst(issue_dst), .issue_src0(issue_src0), .issue_src1(issue_src1),
        .issue_op(issue_op)
    );

    int checks = 0;
    int errors = 0;

    // Reference model state
    bit       m_v   [NW];
    bit       m_cls [NW];
    int       m_dst [NW], m_s0 [NW], m_s1 [NW], m_op [NW];
    bit       m_pend[NW][NR];
    int       m_cnt [2];
    int       m_ptr;
    bit       e_iv;
    int       e_warp, e_cls, e_dst, e_s0, e_s1, e_op;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_ready(input int w);
        return m_v[w] && !m_pend[w][m_s0[w]] && !m_pend[w][m_s1[w]]
               && !m_pend[w][m_dst[w]] && (m_cnt[m_cls[w]] == 0);
    endfunction

    function automatic int m_pick();
        for (int i = 0; i < NW; i++) begin
            int k;
            k = (m_ptr + i) % NW;
            if (m_ready(k)) return k;
        end
        return -1;
    endfunction

    task automatic model_reset();
        for (int w = 0; w < NW; w++) begin
            m_v[w] = 0; m_cls[w] = 0; m_dst[w] = 0; m_s0[w] = 0; m_s1[w] = 0; m_op[w] = 0;
            for (int r = 0; r < NR; r++) m_pend[w][r] = 0;
        end
        m_cnt[0] = 0; m_cnt[1] = 0; m_ptr = 0;
        e_iv = 0; e_warp = 0; e_cls = 0; e_dst = 0; e_s0 = 0; e_s1 = 0; e_op = 0;
    endtask

    task automatic model_step();
        int  g;
        bit  fill_ok;
        int  fw;
        g  = m_pick();
        fw = int'(fill_warp);
        fill_ok = fill_valid && (fw < NW) && !m_v[fw];
        for (int c = 0; c < 2; c++) if (m_cnt[c] > 0) m_cnt[c]--;
        if (wb_valid && int'(wb_warp) < NW) m_pend[wb_warp][wb_reg] = 0;
        e_iv = (g >= 0);
        if (g >= 0) begin
            e_warp = g; e_cls = m_cls[g]; e_dst = m_dst[g];
            e_s0 = m_s0[g]; e_s1 = m_s1[g]; e_op = m_op[g];
            m_pend[g][m_dst[g]] = 1;
            m_cnt[m_cls[g]] = OCC - 1;
            m_v[g] = 0;
            m_ptr = (g + 1) % NW;
        end
        if (fill_ok) begin
            m_v[fw] = 1; m_cls[fw] = fill_class; m_dst[fw] = fill_dst;
            m_s0[fw] = fill_src0; m_s1[fw] = fill_src1; m_op[fw] = fill_op;
        end
    endtask

    task automatic compare_all();
        logic [NW-1:0] mv;
        for (int w = 0; w < NW; w++) mv[w] = m_v[w];
        chk("R2 slot_busy", slot_busy, mv);
        chk("R6 issue_valid", issue_valid, e_iv);
        if (e_iv && issue_valid) begin
            chk("R6 issue_warp", issue_warp, e_warp);
            chk("R7 issue_class", issue_class, e_cls);
            chk("R3 issue_dst", issue_dst, e_dst);
            chk("R3 issue_src0", issue_src0, e_s0);
            chk("R3 issue_src1", issue_src1, e_s1);
            chk("R3 issue_op", issue_op, e_op);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        fill_valid = 1'b0;
        wb_valid   = 1'b0;
    endtask

    task automatic put(input int w, input bit c, input int d, input int a, input int b, input int o);
        fill_valid = 1'b1; fill_warp = WW'(w); fill_class = c;
        fill_dst = RW'(d); fill_src0 = RW'(a); fill_src1 = RW'(b); fill_op = OPW'(o);
    endtask

    task automatic wb(input int w, input int r);
        wb_valid = 1'b1; wb_warp = WW'(w); wb_reg = RW'(r);
    endtask

    task automatic random_wb();
        int start;
        start = int'($urandom_range(0, NW - 1));
        for (int i = 0; i < NW; i++) begin
            int w;
            w = (start + i) % NW;
            for (int r = 0; r < NR; r++) begin
                if (m_pend[w][r] && !wb_valid) wb(w, r);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 issue_valid", issue_valid, 0);
        chk("R1 slot_busy", slot_busy, 0);

        // R2: fill warp 5
        put(5, 0, 1, 2, 3, 8'h11); tick();
        chk("R2 slot set", slot_busy[5], 1);
        chk("R2 no early issue", issue_valid, 0);
        tick();
        chk("R3 issue warp", issue_warp, 5);
        chk("R3 issue dst", issue_dst, 1);
        chk("R3 slot freed", slot_busy[5], 0);
        // R4: source r1 still pending
        put(5, 1, 4, 1, 0, 8'h22); tick();
        put(5, 0, 9, 0, 0, 8'h33); tick();           // ignored fill (R2)
        chk("R4 blocked by pending src", issue_valid, 0);
        wb(5, 1); tick();
        chk("R4 still blocked", issue_valid, 0);
        tick();
        chk("R5 issue after writeback", issue_valid, 1);
        chk("R2 occupied fill ignored dst", issue_dst, 4);
        chk("R7 class SFU", issue_class, 1);
        // R9: independent instruction while r4 pending
        put(5, 0, 6, 7, 8, 8'h44); tick(); tick();
        chk("R9 independent issue", issue_valid, 1);
        chk("R9 dst", issue_dst, 6);
        // R6/R7/R8
        put(2, 0, 1, 2, 3, 8'h55); tick();
        put(9, 0, 1, 2, 3, 8'h66); tick();
        tick();
        chk("R7 MAD still busy", issue_valid, 0);
        tick();
        chk("R6 rr picks warp after pointer", issue_warp, 9);
        put(3, 1, 5, 2, 3, 8'h77); tick();
        chk("R7 no MAD within window", issue_valid, 0);
        tick();
        chk("R8 SFU during MAD busy", issue_valid, 1);
        chk("R8 SFU warp", issue_warp, 3);
        tick();
        chk("R7 gap", issue_valid, 0);
        tick();
        chk("R7 MAD after 4 cycles", issue_warp, 2);
        // R5: same-cycle mark and clear
        put(7, 0, 10, 0, 0, 8'h88); tick(); tick(); tick();
        wb(7, 10); tick();
        chk("R5 warp7 issued", issue_warp, 7);
        put(7, 1, 11, 10, 12, 8'h99); tick(); tick();
        chk("R5 mark beats clear", issue_valid, 0);
        tick();
        wb(7, 10); tick(); tick();
        chk("R5 issue after clear", issue_valid, 1);
        chk("R5 warp", issue_warp, 7);

        // Constrained random phase
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 99) < 60)
                put(int'($urandom_range(0, NW - 1)), 1'($urandom_range(0, 1)),
                    int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                    int'($urandom_range(0, 7)), int'($urandom_range(0, 255)));
            if ($urandom_range(0, 99) < 70) random_wb();
            tick();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule